// File: doc/BRIEF.md
# Phase-Frequency Detector with Charge-Pump Mode Control

This block compares a pulse from the reference divider with a pulse from the main (RF) divider. It produces a pair of UP/DOWN correction pulses for each of two charge pumps. The comparator is a two-flip-flop phase-frequency detector. Each flip-flop is set by a rising edge of its input. Once both are set, they stay set for a programmable number of cycles and are then cleared together. Because of this minimum overlap, in-phase inputs still produce short pulses, so small phase errors never fall into a dead band. A sense input exchanges which divider drives UP and which drives DOWN. This lets the loop polarity match the VCO slope.

Around the detector sits a small mode decoder. It uses two control bits, a digital lock-window flag and a power-down input to decide three things:
- whether the two comparison-frequency ports carry the divider pulses,
- whether pump 1 runs always, never, or only while out of lock,
- whether everything is quiet.

Each pump also gets a 3-bit gain code built from the two gain bits, and an active-low lock output follows the lock-window flag. The divider pulses are brought into the block's clock domain through a parameterised synchroniser before edge detection.

Top module: `phase_det_cp`

## Requirements
- R1: After reset, all four pump outputs and both port outputs are low.
- R2: With sense_i=0, a reference rising edge L cycles ahead of the main-divider edge gives an UP pulse of L+RST_EXT cycles on the enabled pumps and a DOWN pulse of RST_EXT cycles. UP goes high SYNC_STAGES+1 cycles after the reference edge is applied. A lagging reference gives the mirror image on DOWN.
- R3: Coincident edges give UP and DOWN pulses that start in the same cycle and each last exactly RST_EXT cycles.
- R4: With sense_i=1, the main-divider edge sets UP and the reference edge sets DOWN.
- R5: With route_ports_i=1, the ports carry the synchronised pulses SYNC_STAGES cycles after they are applied. With sense_i=0, port_a_o carries the main-divider pulse and port_b_o the reference pulse; with sense_i=1 the two are exchanged. With route_ports_i=0, both ports stay low.
- R6: Pump 2 is enabled whenever the block is powered. Pump 1 is enabled according to lock_gate_i:
  - when lock_gate_i=0, pump 1 is enabled only when route_ports_i=0;
  - when lock_gate_i=1, pump 1 is enabled only when lock_win_i=0.
  A disabled pump's UP/DOWN outputs stay low.
- R7: Each pump's code is {1, gain_i[1], gain_i[0]} while that pump is enabled and 3'b000 otherwise. gain_i values 0,1,2,3 stand for pump 1 currents of 50, 75, 125 and 200 units and pump 2 multipliers of 1, 1.5, 2.5 and 4.
- R8: lock_n_o is the inverse of lock_win_i.
- R9: While pwr_dn_i=1, all pump outputs, ports and codes are zero and the detector state is cleared, so no stale pulse appears after release.
- R10: Two reference edges with no main-divider edge between them keep UP asserted until the main-divider edge arrives, which gives frequency as well as phase detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Comparison clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pulse_i | input | 1 | Reference divider output pulse |
| div_pulse_i | input | 1 | Main divider output pulse |
| sense_i | input | 1 | Swaps detector inputs and port roles |
| gain_i | input | 2 | Pump gain select {G2,G1} |
| route_ports_i | input | 1 | Drive the ports; in plain mode also turns pump 1 off |
| lock_gate_i | input | 1 | Let the lock window gate pump 1 |
| lock_win_i | input | 1 | Loop is inside the lock window |
| pwr_dn_i | input | 1 | Power-down |
| cp1_up_o | output | 1 | Pump 1 source pulse |
| cp1_dn_o | output | 1 | Pump 1 sink pulse |
| cp2_up_o | output | 1 | Pump 2 source pulse |
| cp2_dn_o | output | 1 | Pump 2 sink pulse |
| cp1_code_o | output | 3 | Pump 1 gain code |
| cp2_code_o | output | 3 | Pump 2 gain code |
| port_a_o | output | 1 | Comparison port A |
| port_b_o | output | 1 | Comparison port B |
| lock_n_o | output | 1 | Lock indication, active low |

## Verification
Each result has a fixed delay after its stimulus:
- a port follows an input pulse after SYNC_STAGES edges;
- pump pulses rise one edge later than the ports;
- pump pulses fall RST_EXT edges after the later of the two edges;
- codes, enables and the lock output follow their inputs in the same cycle.

The bench drives one input pattern per cycle at the falling edge and, just before each drive, records every output. It then checks the index of the first high cycle and the count of high cycles against those delays, computed from the two parameters. Mode and gain checks settle for one time unit after the falling-edge drive and then compare.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int CODE_W = 3;
  localparam int GAIN_W = 2;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_drv_t;

  function automatic logic [CODE_W-1:0] gain_code(input logic en, input logic [GAIN_W-1:0] g);
    return en ? {1'b1, g} : '0;
  endfunction
endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
  parameter int N      = 2,
  parameter int STAGES = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  logic [STAGES-1:0][N-1:0] sh_q;
  logic [N-1:0]             prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[s] <= '0;
        else if (s == 0) sh_q[s] <= d_i;
        else sh_q[s] <= sh_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= sh_q[STAGES-1];
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int RST_EXT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_up_i,
  input  logic set_dn_i,
  input  logic clr_i,
  output logic up_o,
  output logic dn_o
);
  localparam int CW = $clog2(RST_EXT + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_EXT - 1);

  logic          up_q, dn_q;
  logic [CW-1:0] cnt_q;
  logic          both, done;

  assign both = up_q & dn_q;
  assign done = both & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i || done) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      up_q  <= up_q | set_up_i;
      dn_q  <= dn_q | set_dn_i;
      cnt_q <= both ? cnt_q + 1'b1 : '0;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

  // overlap ends after RST_EXT cycles
  assert_overlap_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (!up_q && !dn_q));
  assert_pd_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!up_q && !dn_q));
  // a lone UP persists across extra reference edges
  assert_up_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && !dn_q && !clr_i) |=> up_q);
endmodule

// File: rtl/cp_mode_ctrl.sv
module cp_mode_ctrl
  import pfd_pkg::*;
(
  input  logic              route_ports_i,
  input  logic              lock_gate_i,
  input  logic              lock_win_i,
  input  logic              pwr_dn_i,
  input  logic              sense_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  pump_drv_t         drv_i,
  input  logic              ref_lvl_i,
  input  logic              div_lvl_i,
  output pump_drv_t         cp1_o,
  output pump_drv_t         cp2_o,
  output logic [CODE_W-1:0] cp1_code_o,
  output logic [CODE_W-1:0] cp2_code_o,
  output logic              port_a_o,
  output logic              port_b_o,
  output logic              lock_n_o
);
  logic cp1_en, cp2_en, ports_en;

  always_comb begin
    cp2_en   = ~pwr_dn_i;
    ports_en = route_ports_i & ~pwr_dn_i;
    if (lock_gate_i) cp1_en = ~pwr_dn_i & ~lock_win_i;
    else             cp1_en = ~pwr_dn_i & ~route_ports_i;
  end

  assign cp1_o.up   = drv_i.up & cp1_en;
  assign cp1_o.dn   = drv_i.dn & cp1_en;
  assign cp2_o.up   = drv_i.up & cp2_en;
  assign cp2_o.dn   = drv_i.dn & cp2_en;
  assign cp1_code_o = gain_code(cp1_en, gain_i);
  assign cp2_code_o = gain_code(cp2_en, gain_i);
  assign port_a_o   = ports_en & (sense_i ? ref_lvl_i : div_lvl_i);
  assign port_b_o   = ports_en & (sense_i ? div_lvl_i : ref_lvl_i);
  assign lock_n_o   = ~lock_win_i;
endmodule

// File: rtl/phase_det_cp.sv
module phase_det_cp
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 1,
  parameter int RST_EXT     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_pulse_i,
  input  logic              div_pulse_i,
  input  logic              sense_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              route_ports_i,
  input  logic              lock_gate_i,
  input  logic              lock_win_i,
  input  logic              pwr_dn_i,
  output logic              cp1_up_o,
  output logic              cp1_dn_o,
  output logic              cp2_up_o,
  output logic              cp2_dn_o,
  output logic [CODE_W-1:0] cp1_code_o,
  output logic [CODE_W-1:0] cp2_code_o,
  output logic              port_a_o,
  output logic              port_b_o,
  output logic              lock_n_o
);
  logic [1:0] lvl, rise;
  logic       set_up, set_dn;
  pump_drv_t  drv, cp1, cp2;

  pfd_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i   ({div_pulse_i, ref_pulse_i}),
    .lvl_o (lvl),
    .rise_o(rise)
  );

  // sense exchanges the comparator inputs
  assign set_up = sense_i ? rise[1] : rise[0];
  assign set_dn = sense_i ? rise[0] : rise[1];

  pfd_core #(.RST_EXT(RST_EXT)) u_core (
    .clk_i, .rst_ni,
    .set_up_i(set_up),
    .set_dn_i(set_dn),
    .clr_i   (pwr_dn_i),
    .up_o    (drv.up),
    .dn_o    (drv.dn)
  );

  cp_mode_ctrl u_mode (
    .route_ports_i, .lock_gate_i, .lock_win_i, .pwr_dn_i, .sense_i, .gain_i,
    .drv_i    (drv),
    .ref_lvl_i(lvl[0]),
    .div_lvl_i(lvl[1]),
    .cp1_o    (cp1),
    .cp2_o    (cp2),
    .cp1_code_o, .cp2_code_o, .port_a_o, .port_b_o, .lock_n_o
  );

  assign cp1_up_o = cp1.up;
  assign cp1_dn_o = cp1.dn;
  assign cp2_up_o = cp2.up;
  assign cp2_dn_o = cp2.dn;

  assert_ports_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!route_ports_i || pwr_dn_i) |-> (!port_a_o && !port_b_o));
  assert_lock_gates_cp1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_gate_i && lock_win_i) |-> (!cp1_up_o && !cp1_dn_o));
  assert_cp2_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_dn_i && drv.up) |-> cp2_up_o);
  assert_pd_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |-> (cp1_code_o == '0 && cp2_code_o == '0 && !cp2_up_o && !cp2_dn_o));
endmodule

// File: tb/sim_phase_det_cp.sv
module sim_phase_det_cp;
  localparam int S = 1;
  localparam int E = 2;
  localparam int NCYC = 40;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ref_p = 0, div_p = 0, sense = 0, route = 0, lgate = 0, lwin = 0, pd = 0;
  logic [1:0] gain = 2'b00;
  logic cp1u, cp1d, cp2u, cp2d, pa, pb, lockn;
  logic [2:0] c1, c2;
  int checks = 0, errors = 0;
  int upw, dnw, ups, dns, u1w, d1w, pas, pbs;

  always #2 clk = ~clk;

  phase_det_cp #(.SYNC_STAGES(S), .RST_EXT(E)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ref_pulse_i(ref_p), .div_pulse_i(div_p),
    .sense_i(sense), .gain_i(gain), .route_ports_i(route), .lock_gate_i(lgate),
    .lock_win_i(lwin), .pwr_dn_i(pd), .cp1_up_o(cp1u), .cp1_dn_o(cp1d),
    .cp2_up_o(cp2u), .cp2_dn_o(cp2d), .cp1_code_o(c1), .cp2_code_o(c2),
    .port_a_o(pa), .port_b_o(pb), .lock_n_o(lockn));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive ref at tr/tr2 and div at td (-1 = none); record widths and first-high cycles
  task automatic measure(input int tr, input int tr2, input int td);
    upw = 0; dnw = 0; u1w = 0; d1w = 0; ups = -1; dns = -1; pas = -1; pbs = -1;
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      if (cp2u) begin upw++; if (ups < 0) ups = c; end
      if (cp2d) begin dnw++; if (dns < 0) dns = c; end
      if (cp1u) u1w++;
      if (cp1d) d1w++;
      if (pa && pas < 0) pas = c;
      if (pb && pbs < 0) pbs = c;
      ref_p = (c == tr) || (c == tr2);
      div_p = (c == td);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "reset outputs", {cp1u, cp1d, cp2u, cp2d, pa, pb}, 0);
  endtask

  task automatic t_lead_lag_s0;
    sense = 0; route = 1; lgate = 0;
    measure(3, -1, 7);
    chk("R2", "lead up width", upw, 4 + E);
    chk("R2", "lead dn width", dnw, E);
    chk("R2", "lead up start", ups, 3 + S + 1);
    chk("R5", "port_a carries div", pas, 7 + S);
    chk("R5", "port_b carries ref", pbs, 3 + S);
    measure(8, -1, 3);
    chk("R2", "lag dn width", dnw, 5 + E);
    chk("R2", "lag up width", upw, E);
    chk("R2", "lag dn start", dns, 3 + S + 1);
  endtask

  task automatic t_sense1;
    sense = 1; route = 1;
    measure(3, -1, 7);
    chk("R4", "s1 ref lead dn width", dnw, 4 + E);
    chk("R4", "s1 ref lead up width", upw, E);
    chk("R5", "s1 port_a carries ref", pas, 3 + S);
    chk("R5", "s1 port_b carries div", pbs, 7 + S);
    measure(8, -1, 3);
    chk("R4", "s1 div lead up width", upw, 5 + E);
    chk("R4", "s1 div lead up start", ups, 3 + S + 1);
    sense = 0;
  endtask

  task automatic t_inphase;
    measure(5, -1, 5);
    chk("R3", "in-phase up width", upw, E);
    chk("R3", "in-phase dn width", dnw, E);
    chk("R3", "in-phase start match", ups, dns);
  endtask

  task automatic t_freq;
    measure(2, 8, 20);
    chk("R10", "two ref edges up width", upw, 18 + E);
    chk("R10", "two ref edges dn width", dnw, E);
  endtask

  task automatic t_route_off;
    route = 0; lgate = 0;
    measure(3, -1, 6);
    chk("R5", "ports off a", pas, -1);
    chk("R5", "ports off b", pbs, -1);
    chk("R6", "cp1 on in plain mode", u1w, 3 + E);
  endtask

  task automatic t_lock_gate;
    route = 0; lgate = 1; lwin = 1;
    measure(3, -1, 6);
    chk("R6", "cp1 gated in lock", u1w + d1w, 0);
    chk("R6", "cp2 still on in lock", upw, 3 + E);
    lwin = 0;
    measure(3, -1, 6);
    chk("R6", "cp1 on out of lock", u1w, 3 + E);
    lgate = 0;
  endtask

  task automatic t_modes;
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      route = m[0]; lgate = m[1]; lwin = m[2]; gain = 2'(m);
      #1;
      begin
        logic en1;
        en1 = lgate ? !lwin : !route;
        chk("R7", $sformatf("cp1 code mode %0d", m), c1, en1 ? {1'b1, gain} : 0);
        chk("R7", $sformatf("cp2 code mode %0d", m), c2, {1'b1, gain});
        chk("R8", $sformatf("lock_n mode %0d", m), lockn, !lwin);
      end
    end
    route = 0; lgate = 0; lwin = 0;
  endtask

  task automatic t_pd;
    pd = 1; route = 1;
    measure(3, -1, 8);
    chk("R9", "pd pump activity", upw + dnw + u1w + d1w, 0);
    chk("R9", "pd port activity", (pas >= 0) || (pbs >= 0), 0);
    chk("R9", "pd codes", {c1, c2}, 0);
    // leave a lone UP pending, then power down
    pd = 0;
    measure(3, -1, -1);
    pd = 1;
    @(negedge clk);
    pd = 0;
    measure(-1, -1, -1);
    chk("R9", "no stale up after pd", upw, 0);
    route = 0;
  endtask

  initial begin
    #10000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_lead_lag_s0();
    t_sense1();
    t_inphase();
    t_freq();
    t_route_off();
    t_lock_gate();
    t_modes();
    t_pd();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule